// File: doc/BRIEF.md
# DDR Secure Region Access Filter

This block sits in front of a DDR port and decides, for every transaction, whether it may proceed. Software describes up to eight address windows in one-megabyte steps and marks each one as reserved for secure masters. A separate switch protects all memory that lies outside every window. A global bypass switch lets everything through. A non-secure access that lands in protected memory is refused, and the block records the event in a sticky flag together with the address of the first offending access.

Configuration goes through a small 32-bit register port. Every write carries its own bit mask in the upper half of the data word, so one bit can be changed without a read-modify-write. The allow/deny decision is combinational from the access inputs and the stored configuration. The violation record updates on the following clock edge.

Top module: `ddr_sec_filter`

## Requirements
- R1: After reset every window start, window end and enable reads as zero, the control word (index 16) reads 0x200 (bypass set), the violation flag is 0, and every access is allowed.
- R2: A write to index 0..16 changes only stored bit k for which write-data bit k+16 is 1, and loads it from write-data bit k. Writing a mask bit with a zero data bit clears that bit, and all other bits keep their value.
- R3: Reads return the stored field in the low bits with all other bits zero: window start at index 0..7 (12 bits), window end at index 8..15 (12 bits), control at index 16 (bits 7:0 window enables, bit 8 outside enable, bit 9 bypass), the violation flag at index 17 bit 0, and zero for any other index.
- R4: Window n covers an access when address bits 31:20 lie between start[n] and end[n], both ends included. A window whose start exceeds its end covers nothing.
- R5: With bypass clear, a valid non-secure access covered by an enabled window is denied. A secure access is always allowed.
- R6: A window whose enable bit is 0 never causes a denial.
- R7: With control bit 8 set and bypass clear, a valid non-secure access that no window covers is denied.
- R8: With control bit 9 set, every valid access is allowed, whatever the other settings.
- R9: When windows overlap, one enabled covering window is enough to deny, even if another covering window is disabled.
- R10: acc_allow and acc_deny follow the access inputs in the same cycle, exactly one is high while acc_valid is 1, and both are low while acc_valid is 0.
- R11: A denied access sets viol_flag on the next clock edge. viol_addr takes the access address only when the flag was clear, and holds otherwise.
- R12: Writing 1 to bit 0 of index 17 clears viol_flag on the next edge. If a denial happens in the same cycle, the flag stays set and viol_addr takes the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 5 | Register index |
| reg_wdata | input | 32 | Write data: mask in 31:16, data in 15:0 |
| reg_rdata | output | 32 | Read data of the selected register |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access byte address |
| acc_secure | input | 1 | Access carries the secure attribute |
| acc_allow | output | 1 | Access may proceed |
| acc_deny | output | 1 | Access refused |
| viol_flag | output | 1 | Sticky violation flag |
| viol_addr | output | 32 | Address of the first refused access |

## Verification
The bench builds the block with its defaults: eight windows, a 32-bit address and a 1 MB grain. With these values the 12-bit field covers the full 4 GB range, so the top megabyte (0xFFF) and an empty window with start above end can both be exercised. The same setup gives overlap between a disabled window and an enabled one, a last byte of a window checked against the first byte past it, and a violation clear that lands in the same cycle as a new denial.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int unsigned HALF_W = 16;

  // merge masked write: upper half selects which low-half bits are replaced
  function automatic logic [HALF_W-1:0] mask_merge(input logic [HALF_W-1:0] old_v,
                                                  input logic [2*HALF_W-1:0] wd);
    return (old_v & ~wd[2*HALF_W-1:HALF_W]) | (wd[HALF_W-1:0] & wd[2*HALF_W-1:HALF_W]);
  endfunction
endpackage

// File: rtl/dsf_rgn_cmp.sv
module dsf_rgn_cmp #(
  parameter int FLD_W = 12
) (
  input  logic [FLD_W-1:0] page,
  input  logic [FLD_W-1:0] lo,
  input  logic [FLD_W-1:0] hi,
  output logic             hit
);
  // inclusive on both ends; lo > hi cannot satisfy both terms
  always_comb hit = (page >= lo) && (page <= hi);
endmodule

// File: rtl/dsf_regfile.sv
module dsf_regfile
  import dsf_pkg::*;
#(
  parameter int NUM_RGN = 8,
  parameter int FLD_W   = 12,
  parameter int SEL_W   = 5,
  localparam int CTL_W    = NUM_RGN + 2,
  localparam int IDX_CTL  = 2 * NUM_RGN,
  localparam int IDX_VIOL = IDX_CTL + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              sel,
  input  logic [2*HALF_W-1:0]           wdata,
  input  logic                          viol_flag,
  output logic [NUM_RGN-1:0][FLD_W-1:0] rgn_lo,
  output logic [NUM_RGN-1:0][FLD_W-1:0] rgn_hi,
  output logic [NUM_RGN-1:0]            rgn_en,
  output logic                          out_en,
  output logic                          bypass,
  output logic [2*HALF_W-1:0]           rdata
);
  logic [NUM_RGN-1:0][FLD_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [NUM_RGN-1:0]            lo_we, hi_we;
  logic [CTL_W-1:0]              ctl_q, ctl_d;
  logic                          ctl_we;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    always_comb begin
      lo_we[g] = wr_en && (sel == SEL_W'(g));
      hi_we[g] = wr_en && (sel == SEL_W'(g + NUM_RGN));
      lo_d[g]  = FLD_W'(mask_merge(HALF_W'(lo_q[g]), wdata));
      hi_d[g]  = FLD_W'(mask_merge(HALF_W'(hi_q[g]), wdata));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= '0;
      end else if (lo_we[g]) begin
        lo_q[g] <= lo_d[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[g] <= '0;
      end else if (hi_we[g]) begin
        hi_q[g] <= hi_d[g];
      end
    end
  end

  always_comb begin
    ctl_we = wr_en && (sel == SEL_W'(IDX_CTL));
    ctl_d  = CTL_W'(mask_merge(HALF_W'(ctl_q), wdata));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= {1'b1, {(CTL_W-1){1'b0}}};
    end else if (ctl_we) begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    rgn_lo = lo_q;
    rgn_hi = hi_q;
    rgn_en = ctl_q[NUM_RGN-1:0];
    out_en = ctl_q[NUM_RGN];
    bypass = ctl_q[NUM_RGN+1];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_RGN; i++) begin
      if (sel == SEL_W'(i))           rdata[FLD_W-1:0] = lo_q[i];
      if (sel == SEL_W'(i + NUM_RGN)) rdata[FLD_W-1:0] = hi_q[i];
    end
    if (sel == SEL_W'(IDX_CTL))  rdata[CTL_W-1:0] = ctl_q;
    if (sel == SEL_W'(IDX_VIOL)) rdata[0]         = viol_flag;
  end
endmodule

// File: rtl/dsf_viol_trk.sv
module dsf_viol_trk #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deny,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clr,
  output logic              flag,
  output logic [ADDR_W-1:0] addr_q
);
  logic              flag_d, flag_we;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_we;

  always_comb begin
    flag_we = deny || clr;
    flag_d  = deny;              // a new denial wins over a clear
    addr_we = deny && (!flag || clr);
    addr_d  = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (flag_we) begin
      flag <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_we) begin
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/ddr_sec_filter.sv
module ddr_sec_filter #(
  parameter int NUM_RGN    = 8,
  parameter int ADDR_W     = 32,
  parameter int GRAIN_LOG2 = 20,
  localparam int SEL_W     = $clog2(2 * NUM_RGN + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_secure,
  output logic              acc_allow,
  output logic              acc_deny,
  output logic              viol_flag,
  output logic [ADDR_W-1:0] viol_addr
);
  localparam int FLD_W    = ADDR_W - GRAIN_LOG2;
  localparam int IDX_VIOL = 2 * NUM_RGN + 1;

  logic [NUM_RGN-1:0][FLD_W-1:0] rgn_lo, rgn_hi;
  logic [NUM_RGN-1:0]            rgn_en, rgn_hit;
  logic                          out_en, ctl_bypass;
  logic [FLD_W-1:0]              acc_page;
  logic                          viol_clr, prot_hit;

  dsf_regfile #(.NUM_RGN(NUM_RGN), .FLD_W(FLD_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .viol_flag(viol_flag), .rgn_lo(rgn_lo), .rgn_hi(rgn_hi), .rgn_en(rgn_en),
    .out_en(out_en), .bypass(ctl_bypass), .rdata(reg_rdata)
  );

  always_comb acc_page = acc_addr[ADDR_W-1:GRAIN_LOG2];

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
    dsf_rgn_cmp #(.FLD_W(FLD_W)) u_cmp (
      .page(acc_page), .lo(rgn_lo[g]), .hi(rgn_hi[g]), .hit(rgn_hit[g])
    );
  end

  always_comb begin
    prot_hit  = (|(rgn_hit & rgn_en)) || (out_en && !(|rgn_hit));
    acc_deny  = acc_valid && !ctl_bypass && !acc_secure && prot_hit;
    acc_allow = acc_valid && !acc_deny;
    viol_clr  = reg_wr && (reg_sel == SEL_W'(IDX_VIOL)) && reg_wdata[0];
  end

  dsf_viol_trk #(.ADDR_W(ADDR_W)) u_viol (
    .clk(clk), .rst_n(rst_n), .deny(acc_deny), .addr(acc_addr), .clr(viol_clr),
    .flag(viol_flag), .addr_q(viol_addr)
  );
endmodule

// File: rtl/dsf_sva.sv
module dsf_sva #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 5,
  parameter int IDX_VIOL = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [SEL_W-1:0]  reg_sel,
  input logic [31:0]       reg_wdata,
  input logic              acc_valid,
  input logic              acc_secure,
  input logic              acc_allow,
  input logic              acc_deny,
  input logic              bypass,
  input logic              viol_flag,
  input logic [ADDR_W-1:0] viol_addr
);
  logic clr_req;
  always_comb clr_req = reg_wr && (reg_sel == SEL_W'(IDX_VIOL)) && reg_wdata[0];

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_allow && !acc_deny));

  // R10
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $onehot({acc_allow, acc_deny}));

  // R5
  secure_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_secure) |-> acc_allow);

  // R8
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> !acc_deny);

  // R11
  deny_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_deny |=> viol_flag);

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !clr_req) |=> (viol_flag && $stable(viol_addr)));

  // R12
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !acc_deny) |=> !viol_flag);
endmodule

bind ddr_sec_filter dsf_sva #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .IDX_VIOL(IDX_VIOL)) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .acc_valid(acc_valid), .acc_secure(acc_secure), .acc_allow(acc_allow),
  .acc_deny(acc_deny), .bypass(ctl_bypass), .viol_flag(viol_flag), .viol_addr(viol_addr)
);

// File: tb/sim_ddr_sec_filter.sv
`timescale 1ns/1ps
module sim_ddr_sec_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_secure = 1'b0;
  logic        acc_allow, acc_deny, viol_flag;
  logic [31:0] viol_addr;

  int n_chk = 0;
  int n_err = 0;

  // reference state
  int          m_lo[8];
  int          m_hi[8];
  int          m_ctl;
  bit          m_vf;
  logic [31:0] m_va;

  always #2 clk = ~clk;

  ddr_sec_filter u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_secure(acc_secure), .acc_allow(acc_allow), .acc_deny(acc_deny),
    .viol_flag(viol_flag), .viol_addr(viol_addr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int merge(input int old_v, input logic [31:0] wd, input int width);
    int m;
    m = int'(wd[31:16]) & ((1 << width) - 1);
    return (old_v & ~m) | (int'(wd[15:0]) & m);
  endfunction

  // one clock: drive, compare against the model, then advance the model
  task automatic step(input string req, input bit wr, input int sel, input logic [31:0] wd,
                      input bit v, input logic [31:0] a, input bit s);
    int pg;
    bit any_hit, en_hit, dn, clr;
    logic [31:0] exp_rd;
    @(negedge clk);
    reg_wr = wr; reg_sel = 5'(sel); reg_wdata = wd;
    acc_valid = v; acc_addr = a; acc_secure = s;
    #1;
    pg = int'(a >> 20);
    any_hit = 0; en_hit = 0;
    for (int i = 0; i < 8; i++) begin
      if (m_lo[i] <= pg && pg <= m_hi[i]) begin
        any_hit = 1;
        if (m_ctl[i]) en_hit = 1;
      end
    end
    dn = v && !m_ctl[9] && !s && (en_hit || (m_ctl[8] && !any_hit));
    if (sel < 8)       exp_rd = 32'(m_lo[sel]);
    else if (sel < 16) exp_rd = 32'(m_hi[sel-8]);
    else if (sel == 16) exp_rd = 32'(m_ctl);
    else if (sel == 17) exp_rd = {31'd0, m_vf};
    else               exp_rd = 32'd0;
    chk(req, "deny", {31'd0, acc_deny}, {31'd0, dn});
    chk(req, "allow", {31'd0, acc_allow}, {31'd0, v && !dn});
    chk(req, "rdata", reg_rdata, exp_rd);
    chk(req, "viol_flag", {31'd0, viol_flag}, {31'd0, m_vf});
    chk(req, "viol_addr", viol_addr, m_va);
    // state after the coming edge
    clr = wr && sel == 17 && wd[0];
    if (dn) begin
      if (!m_vf || clr) m_va = a;
      m_vf = 1;
    end else if (clr) begin
      m_vf = 0;
    end
    if (wr && sel < 8)       m_lo[sel]   = merge(m_lo[sel], wd, 12);
    else if (wr && sel < 16) m_hi[sel-8] = merge(m_hi[sel-8], wd, 12);
    else if (wr && sel == 16) m_ctl      = merge(m_ctl, wd, 10);
  endtask

  task automatic wr_reg(input string req, input int sel, input logic [31:0] wd);
    step(req, 1, sel, wd, 0, 32'h0, 0);
  endtask
  task automatic rd_reg(input string req, input int sel);
    step(req, 0, sel, 32'h0, 0, 32'h0, 0);
  endtask
  task automatic acc(input string req, input logic [31:0] a, input bit s);
    step(req, 0, 17, 32'h0, 1, a, s);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
    m_ctl = 'h200; m_vf = 0; m_va = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset contents and bypass
    for (int i = 0; i < 18; i++) rd_reg("R1", i);
    acc("R1", 32'h0000_0000, 0);
    acc("R1", 32'h8000_0000, 0);

    // R2 masked writes
    wr_reg("R2", 0, 32'h0FFF_0ABC);
    wr_reg("R2", 0, 32'h000F_0005);
    wr_reg("R2", 0, 32'h0000_0123);
    rd_reg("R2", 0);
    wr_reg("R2", 8, 32'hFFFF_FFFF);
    rd_reg("R2", 8);
    wr_reg("R2", 0, 32'h0FFF_0002);
    wr_reg("R2", 8, 32'h0FFF_0005);

    // R3 unimplemented bits and indices
    wr_reg("R3", 16, 32'hFC00_FC00);
    rd_reg("R3", 16);
    rd_reg("R3", 20);
    rd_reg("R3", 31);

    // R4 empty window 1 (start 10, end 8); enable 0,1 and drop bypass
    wr_reg("R4", 1, 32'h0FFF_000A);
    wr_reg("R4", 9, 32'h0FFF_0008);
    wr_reg("R5", 16, 32'h0203_0003);
    rd_reg("R5", 16);
    acc("R4", 32'h0010_0000, 0);
    acc("R4", 32'h0020_0000, 0);
    acc("R4", 32'h005F_FFFF, 0);
    acc("R4", 32'h0060_0000, 0);
    acc("R4", 32'h0090_0000, 0);
    acc("R5", 32'h0030_0000, 1);
    rd_reg("R11", 17);
    step("R10", 0, 16, 32'h0, 0, 32'h0030_0000, 0);

    // R12 clear, then clear colliding with a denial
    wr_reg("R12", 17, 32'h0000_0001);
    rd_reg("R12", 17);
    step("R12", 1, 17, 32'h0000_0001, 1, 32'h0040_0000, 0);
    rd_reg("R12", 17);
    acc("R11", 32'h0020_0000, 0);
    rd_reg("R11", 17);

    // R6 disabled window 2 (20..30)
    wr_reg("R6", 2, 32'h0FFF_0014);
    wr_reg("R6", 10, 32'h0FFF_001E);
    acc("R6", 32'h0190_0000, 0);

    // R9 enabled window 3 (20..22) overlaps disabled window 2
    wr_reg("R9", 3, 32'h0FFF_0014);
    wr_reg("R9", 11, 32'h0FFF_0016);
    wr_reg("R9", 16, 32'h0008_0008);
    acc("R9", 32'h0150_0000, 0);
    acc("R9", 32'h0170_0000, 0);

    // R7 memory outside every window
    wr_reg("R7", 16, 32'h0100_0100);
    acc("R7", 32'h0640_0000, 0);
    acc("R7", 32'h0190_0000, 0);
    acc("R7", 32'hFFFF_FFFF, 0);
    acc("R7", 32'hFFF0_0000, 1);

    // R2 clear a single enable bit with mask and zero data
    wr_reg("R2", 16, 32'h0001_0000);
    rd_reg("R2", 16);
    acc("R2", 32'h0020_0000, 0);

    // R8 bypass overrides everything
    wr_reg("R8", 17, 32'h0000_0001);
    wr_reg("R8", 16, 32'h0200_0200);
    acc("R8", 32'h0150_0000, 0);
    acc("R8", 32'h0640_0000, 0);
    rd_reg("R8", 17);

    step("R10", 0, 16, 32'h0, 0, 32'h0, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule